// File: doc/BRIEF.md
# I2C Channel Readback Target

This block is the target-side serial front end for a bank of four 16-bit channel words, each paired with a small power-down code. A bus controller addresses the target with a write and sends one control byte. That byte picks the channel and chooses whether a status byte comes first. The controller then issues a repeated START and the address again with the read flag set, and clocks the stored data back out. Channel words and power-down codes reach the block through a parallel preload port. The serial side never writes them.

SCL and SDA are sampled on the system clock, which must run at least sixteen times the SCL rate. Each line passes through a synchronizer and a glitch filter. SDA is open-drain: the block only asserts a drive-low enable. The 7-bit target address is `1,0,0,1,1` followed by two strap inputs. Two more straps must match the top two bits of the control byte before that byte is accepted. The control byte also carries two load bits and a spare bit. These are accepted but have no effect, because this block has no output stage.

Top module: `i2c_chan_readback`

## Requirements
- R1: The target ACKs an address byte (MSB first) only if its upper seven bits equal `1,0,0,1,1,strap_addr[1],strap_addr[0]`; bit 0 is the read flag (1 = read). On a mismatch it sends no ACK and drives SDA low for no bit until the next START or STOP.
- R2: After a matching write address, the target ACKs the next byte when its bits 7:6 equal `strap_ext[1:0]`.
- R3: A control byte whose bits 7:6 differ from `strap_ext` is NACKed, and the channel choice and read length from the last accepted control byte remain in force.
- R4: Control-byte bits 2:1 select the channel (0 to 3) whose word is returned by following reads.
- R5: With control-byte bit 0 clear, a read returns the channel word as high byte (bits 15:8) and then low byte (bits 7:0).
- R6: With control-byte bit 0 set, a read returns a status byte `{pd[1], pd[0], 1,1,1,1,1,1}` of the selected channel, then the high byte, then the low byte.
- R7: Bytes requested after the last data byte read as 0xFF.
- R8: After the controller NACKs a byte, the target releases SDA. A repeated START, with or without a STOP in between, returns it to address decoding.
- R9: The channel word and status code are captured when the read address is acknowledged. Preload writes during that read do not alter the bytes still to be sent.
- R10: The target changes its SDA drive only while SCL is low.
- R11: After reset, SDA is released, and a read with no prior control byte returns channel 0 in the two-byte form.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled SCL line |
| sda_i | input | 1 | Sampled SDA line |
| sda_oe | output | 1 | Drive-low enable for SDA |
| strap_addr | input | 2 | Low two bits of the target address |
| strap_ext | input | 2 | Value the control-byte bits 7:6 must match |
| pre_we | input | 1 | Preload write strobe |
| pre_sel | input | 2 | Channel written by a preload |
| pre_word | input | 16 | Channel word for the preload |
| pre_pd | input | 2 | Power-down code for the preload |

## Verification
The readback path is exercised on several channels in both lengths, and with over-reads that run past the last data byte. Distinct words per channel show whether channel select and byte order are right. Matched and mismatched address and extension straps separate acceptance from rejection. A read after a rejected control byte shows that the old selection persists. A preload issued between the bytes of a read tells a captured snapshot from a live view. A repeated START straight after a NACK shows whether the target re-enters address decoding without a STOP.

// File: rtl/i2c_rb_pkg.sv
package i2c_rb_pkg;
   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ADDR,
      ST_AACK_W,
      ST_CTRL,
      ST_CACK,
      ST_AACK_R,
      ST_TX,
      ST_RACK,
      ST_IGNORE
   } rb_state_e;
endpackage

// File: rtl/i2c_rb_deglitch.sv
module i2c_rb_deglitch #(
   parameter int SYNC_N = 2,
   parameter int FILT_N = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_i,
   output logic line_o
);
   localparam int CNT_W = (FILT_N > 1) ? $clog2(FILT_N) : 1;

   if (SYNC_N < 2) begin : g_bad_sync
      $error("SYNC_N must be at least 2");
   end

   logic [SYNC_N-1:0] sync_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[SYNC_N-2:0], line_i};
   end

   if (FILT_N <= 1) begin : g_bypass
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) line_o <= 1'b1;
         else        line_o <= sync_q[SYNC_N-1];
      end
   end else begin : g_filter
      logic [CNT_W-1:0] cnt_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            line_o <= 1'b1;
            cnt_q  <= '0;
         end else if (sync_q[SYNC_N-1] == line_o) begin
            cnt_q <= '0;
         end else if (cnt_q == CNT_W'(FILT_N - 1)) begin
            line_o <= sync_q[SYNC_N-1];
            cnt_q  <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/i2c_rb_events.sv
module i2c_rb_events (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_f,
   input  logic sda_f,
   output logic scl_rise,
   output logic scl_fall,
   output logic ev_start,
   output logic ev_stop
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_f;
         sda_q <= sda_f;
      end
   end

   assign scl_rise = scl_f & ~scl_q;
   assign scl_fall = ~scl_f & scl_q;
   assign ev_start = scl_f & scl_q & sda_q & ~sda_f;
   assign ev_stop  = scl_f & scl_q & ~sda_q & sda_f;
endmodule

// File: rtl/i2c_rb_bank.sv
module i2c_rb_bank #(
   parameter int CH_COUNT = 4,
   parameter int WORD_W   = 16,
   parameter int PD_W     = 2,
   localparam int SEL_W   = $clog2(CH_COUNT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pre_we,
   input  logic [SEL_W-1:0]  pre_sel,
   input  logic [WORD_W-1:0] pre_word,
   input  logic [PD_W-1:0]   pre_pd,
   input  logic              latch_en,
   input  logic [SEL_W-1:0]  rd_sel,
   output logic [WORD_W-1:0] lat_word,
   output logic [PD_W-1:0]   lat_pd
);
   logic [WORD_W-1:0] word_q [CH_COUNT];
   logic [PD_W-1:0]   pd_q   [CH_COUNT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int c = 0; c < CH_COUNT; c++) begin
            word_q[c] <= '0;
            pd_q[c]   <= '0;
         end
      end else if (pre_we) begin
         word_q[pre_sel] <= pre_word;
         pd_q[pre_sel]   <= pre_pd;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_word <= '0;
         lat_pd   <= '0;
      end else if (latch_en) begin
         lat_word <= word_q[rd_sel];
         lat_pd   <= pd_q[rd_sel];
      end
   end
endmodule

// File: rtl/i2c_rb_engine.sv
module i2c_rb_engine
   import i2c_rb_pkg::*;
#(
   parameter logic [4:0] ADDR_FIXED = 5'b10011,
   parameter int WORD_W = 16,
   parameter int PD_W   = 2,
   parameter int SEL_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              ev_start,
   input  logic              ev_stop,
   input  logic              sda_f,
   input  logic [1:0]        strap_addr,
   input  logic [1:0]        strap_ext,
   input  logic [WORD_W-1:0] lat_word,
   input  logic [PD_W-1:0]   lat_pd,
   output logic              sda_oe,
   output logic [SEL_W-1:0]  rd_sel,
   output logic              latch_en,
   output rb_state_e         state_o
);
   rb_state_e  state;
   logic [3:0] bitcnt;
   logic [7:0] rx_sh, tx_sh, nb;
   logic [1:0] byte_idx;
   logic       pd0_q, nack_q;
   logic       addr_hit, ctrl_hit;

   assign addr_hit = (rx_sh[7:1] == {ADDR_FIXED, strap_addr});
   assign ctrl_hit = (rx_sh[7:6] == strap_ext);
   assign latch_en = (state == ST_ADDR) && scl_fall && (bitcnt == 4'd8) &&
                     addr_hit && rx_sh[0] && !ev_start && !ev_stop;
   assign state_o  = state;

   always_comb begin
      nb = 8'hFF;
      if (pd0_q) begin
         case (byte_idx)
            2'd0:    nb = {lat_pd, {(8-PD_W){1'b1}}};
            2'd1:    nb = lat_word[WORD_W-1 -: 8];
            2'd2:    nb = lat_word[7:0];
            default: nb = 8'hFF;
         endcase
      end else begin
         case (byte_idx)
            2'd0:    nb = lat_word[WORD_W-1 -: 8];
            2'd1:    nb = lat_word[7:0];
            default: nb = 8'hFF;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         bitcnt   <= '0;
         rx_sh    <= '0;
         tx_sh    <= 8'hFF;
         byte_idx <= '0;
         rd_sel   <= '0;
         pd0_q    <= 1'b0;
         sda_oe   <= 1'b0;
         nack_q   <= 1'b0;
      end else if (ev_start) begin
         state  <= ST_ADDR;
         bitcnt <= '0;
         sda_oe <= 1'b0;
      end else if (ev_stop) begin
         state  <= ST_IDLE;
         sda_oe <= 1'b0;
      end else begin
         case (state)
            ST_ADDR, ST_CTRL: begin
               if (scl_rise && bitcnt != 4'd8) begin
                  rx_sh  <= {rx_sh[6:0], sda_f};
                  bitcnt <= bitcnt + 4'd1;
               end else if (scl_fall && bitcnt == 4'd8) begin
                  bitcnt <= '0;
                  if (state == ST_ADDR) begin
                     if (addr_hit) begin
                        sda_oe   <= 1'b1;
                        byte_idx <= '0;
                        state    <= rx_sh[0] ? ST_AACK_R : ST_AACK_W;
                     end else begin
                        state <= ST_IGNORE;
                     end
                  end else if (ctrl_hit) begin
                     rd_sel <= rx_sh[2:1];
                     pd0_q  <= rx_sh[0];
                     sda_oe <= 1'b1;
                     state  <= ST_CACK;
                  end else begin
                     state <= ST_IGNORE;
                  end
               end
            end
            ST_AACK_W: if (scl_fall) begin
               sda_oe <= 1'b0;
               state  <= ST_CTRL;
            end
            ST_CACK: if (scl_fall) begin
               sda_oe <= 1'b0;
               state  <= ST_IGNORE;
            end
            ST_AACK_R: if (scl_fall) begin
               tx_sh    <= nb;
               sda_oe   <= ~nb[7];
               byte_idx <= 2'd1;
               bitcnt   <= '0;
               state    <= ST_TX;
            end
            ST_TX: if (scl_fall) begin
               if (bitcnt == 4'd7) begin
                  sda_oe <= 1'b0;
                  bitcnt <= '0;
                  state  <= ST_RACK;
               end else begin
                  tx_sh  <= {tx_sh[6:0], 1'b1};
                  sda_oe <= ~tx_sh[6];
                  bitcnt <= bitcnt + 4'd1;
               end
            end
            ST_RACK: begin
               if (scl_rise) begin
                  nack_q <= sda_f;
               end else if (scl_fall) begin
                  if (nack_q) begin
                     state <= ST_IGNORE;
                  end else begin
                     tx_sh  <= nb;
                     sda_oe <= ~nb[7];
                     if (byte_idx != 2'd3) byte_idx <= byte_idx + 2'd1;
                     state  <= ST_TX;
                  end
               end
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/i2c_chan_readback.sv
module i2c_chan_readback
   import i2c_rb_pkg::*;
#(
   parameter logic [4:0] ADDR_FIXED = 5'b10011,
   parameter int CH_COUNT = 4,
   parameter int WORD_W   = 16,
   parameter int PD_W     = 2,
   parameter int SYNC_N   = 2,
   parameter int FILT_N   = 3,
   localparam int SEL_W   = $clog2(CH_COUNT)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              sda_oe,
   input  logic [1:0]        strap_addr,
   input  logic [1:0]        strap_ext,
   input  logic              pre_we,
   input  logic [SEL_W-1:0]  pre_sel,
   input  logic [WORD_W-1:0] pre_word,
   input  logic [PD_W-1:0]   pre_pd
);
   if (CH_COUNT != 4) begin : g_bad_ch
      $error("CH_COUNT must be 4: the control byte carries two select bits");
   end
   if (WORD_W != 16) begin : g_bad_word
      $error("WORD_W must be 16: words are returned as two bytes");
   end
   if (PD_W < 1 || PD_W > 7) begin : g_bad_pd
      $error("PD_W must lie in 1..7");
   end

   logic [1:0] raw_lines, filt_lines;
   assign raw_lines = {scl_i, sda_i};

   for (genvar i = 0; i < 2; i++) begin : g_line
      i2c_rb_deglitch #(.SYNC_N(SYNC_N), .FILT_N(FILT_N)) u_dg (
         .clk(clk), .rst_n(rst_n), .line_i(raw_lines[i]), .line_o(filt_lines[i])
      );
   end

   logic scl_f, sda_f, scl_rise, scl_fall, ev_start, ev_stop, latch_en;
   logic [SEL_W-1:0]  rd_sel;
   logic [WORD_W-1:0] lat_word;
   logic [PD_W-1:0]   lat_pd;
   rb_state_e         eng_state;

   assign scl_f = filt_lines[1];
   assign sda_f = filt_lines[0];

   i2c_rb_events u_ev (
      .clk(clk), .rst_n(rst_n), .scl_f(scl_f), .sda_f(sda_f),
      .scl_rise(scl_rise), .scl_fall(scl_fall), .ev_start(ev_start), .ev_stop(ev_stop)
   );

   i2c_rb_bank #(.CH_COUNT(CH_COUNT), .WORD_W(WORD_W), .PD_W(PD_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .pre_we(pre_we), .pre_sel(pre_sel),
      .pre_word(pre_word), .pre_pd(pre_pd), .latch_en(latch_en),
      .rd_sel(rd_sel), .lat_word(lat_word), .lat_pd(lat_pd)
   );

   i2c_rb_engine #(.ADDR_FIXED(ADDR_FIXED), .WORD_W(WORD_W), .PD_W(PD_W), .SEL_W(SEL_W)) u_eng (
      .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
      .ev_start(ev_start), .ev_stop(ev_stop), .sda_f(sda_f),
      .strap_addr(strap_addr), .strap_ext(strap_ext),
      .lat_word(lat_word), .lat_pd(lat_pd), .sda_oe(sda_oe),
      .rd_sel(rd_sel), .latch_en(latch_en), .state_o(eng_state)
   );
endmodule

// File: rtl/i2c_rb_chk.sv
module i2c_rb_chk
   import i2c_rb_pkg::*;
(
   input logic      clk,
   input logic      rst_n,
   input logic      sda_oe,
   input logic      scl_f,
   input logic      ev_start,
   input logic      ev_stop,
   input rb_state_e eng_state
);
   AST_DRIVE_CHANGE_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (sda_oe != $past(sda_oe)) |-> !scl_f); // R10

   AST_IGNORE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_state == ST_IGNORE) |-> !sda_oe); // R8

   AST_START_DECODES: assert property (@(posedge clk) disable iff (!rst_n)
      ev_start |=> (eng_state == ST_ADDR)); // R8

   AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_stop && !ev_start) |=> (eng_state == ST_IDLE && !sda_oe)); // R8

   AST_ACK_DRIVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_state == ST_AACK_W || eng_state == ST_AACK_R || eng_state == ST_CACK) |-> sda_oe); // R2

   AST_START_NOT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      ev_start |-> !sda_oe); // R10
endmodule

bind i2c_chan_readback i2c_rb_chk u_chk (
   .clk(clk), .rst_n(rst_n), .sda_oe(sda_oe), .scl_f(scl_f),
   .ev_start(ev_start), .ev_stop(ev_stop), .eng_state(eng_state)
);

// File: tb/sim_i2c_chan_readback.sv
`timescale 1ns/1ps
module sim_i2c_chan_readback;
   localparam int Q = 100;
   localparam int WD_LIMIT = 150000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic m_scl = 1'b1;
   logic m_sda_low = 1'b0;
   logic sda_oe, sda_bus;
   logic [1:0] strap_addr = 2'b01;
   logic [1:0] strap_ext  = 2'b10;
   logic pre_we = 1'b0;
   logic [1:0] pre_sel = '0;
   logic [15:0] pre_word = '0;
   logic [1:0] pre_pd = '0;

   always #5 clk = ~clk;
   assign sda_bus = ~(m_sda_low | sda_oe);

   i2c_chan_readback u0 (
      .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe(sda_oe),
      .strap_addr(strap_addr), .strap_ext(strap_ext),
      .pre_we(pre_we), .pre_sel(pre_sel), .pre_word(pre_word), .pre_pd(pre_pd)
   );

   int n_chk = 0, n_err = 0, cyc = 0, hi_cnt = 0, r10_viol = 0;
   logic oe_prev = 1'b0;

   // reference model state
   logic [15:0] mdl_word [4];
   logic [1:0]  mdl_pd   [4];
   logic [1:0]  mdl_sel  = 2'd0;
   bit          mdl_pd0  = 1'b0;
   int          exp_q[$];

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   // R10 monitor: drive must hold while SCL has been high for a while
   always @(negedge clk) begin
      cyc++;
      if (m_scl) hi_cnt++; else hi_cnt = 0;
      if (rst_n && hi_cnt > 8 && sda_oe != oe_prev) r10_viol++;
      oe_prev = sda_oe;
      if (cyc == WD_LIMIT) begin
         n_chk++; n_err++;
         $display("FAIL watchdog actual=%0d expected<%0d", cyc, WD_LIMIT);
         $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
         $finish;
      end
   end

   task automatic preload(input int ch, input logic [15:0] w, input logic [1:0] p);
      @(negedge clk);
      pre_we = 1'b1; pre_sel = 2'(ch); pre_word = w; pre_pd = p;
      @(negedge clk);
      pre_we = 1'b0;
      mdl_word[ch] = w; mdl_pd[ch] = p;
   endtask

   task automatic bus_start();
      m_sda_low = 1'b1; #Q; m_scl = 1'b0; #Q;
   endtask
   task automatic bus_rstart();
      m_sda_low = 1'b0; #Q; m_scl = 1'b1; #Q; m_sda_low = 1'b1; #Q; m_scl = 1'b0; #Q;
   endtask
   task automatic bus_stop();
      m_sda_low = 1'b1; #Q; m_scl = 1'b1; #Q; m_sda_low = 1'b0; #Q;
   endtask

   task automatic put_byte(input logic [7:0] b, output bit acked);
      for (int i = 7; i >= 0; i--) begin
         m_sda_low = ~b[i]; #Q; m_scl = 1'b1; #(2*Q); m_scl = 1'b0; #Q;
      end
      m_sda_low = 1'b0; #Q; m_scl = 1'b1; #Q;
      acked = ~sda_bus;
      #Q; m_scl = 1'b0; #Q;
   endtask

   task automatic get_byte(input bit nack, output logic [7:0] b);
      m_sda_low = 1'b0;
      for (int i = 7; i >= 0; i--) begin
         #Q; m_scl = 1'b1; #Q; b[i] = sda_bus; #Q; m_scl = 1'b0;
      end
      #Q; m_sda_low = ~nack; #Q; m_scl = 1'b1; #(2*Q); m_scl = 1'b0; #20; m_sda_low = 1'b0; #(Q-20);
   endtask

   function automatic logic [7:0] addr_byte(input bit rd);
      return {5'b10011, strap_addr, rd};
   endfunction

   task automatic build_expect(input int nbytes);
      exp_q.delete();
      if (mdl_pd0) exp_q.push_back({mdl_pd[mdl_sel], 6'h3F});
      exp_q.push_back(int'(mdl_word[mdl_sel][15:8]));
      exp_q.push_back(int'(mdl_word[mdl_sel][7:0]));
      while (exp_q.size() < nbytes) exp_q.push_back(8'hFF);
   endtask

   // Optional control write, then read nbytes; mid_ch>=0 preloads that channel after byte 0.
   task automatic run_read(input bit send_ctrl, input logic [7:0] ctrl, input int nbytes,
                           input string tag, input int mid_ch, input bit do_stop);
      bit ack;
      logic [7:0] got;
      bit accept;
      bus_start();
      if (send_ctrl) begin
         put_byte(addr_byte(1'b0), ack);
         chk("R2 write-address ACK", int'(ack), 1);
         put_byte(ctrl, ack);
         accept = (ctrl[7:6] == strap_ext);
         chk(accept ? "R2 control ACK" : "R3 control NACK", int'(ack), int'(accept));
         if (accept) begin
            mdl_sel = ctrl[2:1];
            mdl_pd0 = ctrl[0];
         end
         bus_rstart();
      end
      put_byte(addr_byte(1'b1), ack);
      chk("R1 read-address ACK", int'(ack), 1);
      build_expect(nbytes);
      for (int k = 0; k < nbytes; k++) begin
         get_byte(k == nbytes - 1, got);
         chk(tag, int'(got), exp_q[k]);
         if (k == 0 && mid_ch >= 0) preload(mid_ch, 16'h0BAD, 2'b01);
      end
      if (do_stop) bus_stop();
   endtask

   initial begin
      bit ack;
      logic [7:0] got;
      for (int c = 0; c < 4; c++) begin mdl_word[c] = '0; mdl_pd[c] = '0; end
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R11 SDA released after reset", int'(sda_oe), 0);

      preload(0, 16'hA15C, 2'b10);
      preload(1, 16'h1234, 2'b01);
      preload(2, 16'hC3E7, 2'b11);
      preload(3, 16'h5A0F, 2'b00);

      // R11: read without control byte: channel 0, two bytes
      run_read(1'b0, 8'h00, 2, "R11 default channel 0 readback", -1, 1'b1);
      // R4 R5: channel 2, two bytes (ctrl = ext 10, load 00, x0, sel 10, pd0 0)
      run_read(1'b1, 8'b10_00_0_10_0, 2, "R4 R5 channel 2 two-byte readback", -1, 1'b1);
      // R6: channel 1 with status byte
      run_read(1'b1, 8'b10_11_0_01_1, 3, "R6 channel 1 status+data readback", -1, 1'b1);
      // R7: channel 3, over-read two bytes past the end
      run_read(1'b1, 8'b10_00_0_11_0, 4, "R7 over-read returns 0xFF", -1, 1'b1);
      // R3: mismatched extension bits, previous selection (ch3, two bytes) stays
      run_read(1'b1, 8'b01_00_0_01_1, 2, "R3 selection kept after rejected control", -1, 1'b1);
      // R9: preload of the selected channel after the first byte does not tear the word
      run_read(1'b1, 8'b10_00_0_00_1, 3, "R9 snapshot held during read", 0, 1'b1);

      // R1: wrong address is ignored, target never pulls SDA
      bus_start();
      put_byte({5'b10011, ~strap_addr, 1'b1}, ack);
      chk("R1 mismatched address not ACKed", int'(ack), 0);
      get_byte(1'b1, got);
      chk("R1 no drive after mismatch", int'(got), 8'hFF);
      bus_stop();

      // R8: NACK then repeated START with no STOP returns to address decoding
      run_read(1'b1, 8'b10_00_0_10_0, 2, "R8 read before repeated START", -1, 1'b0);
      bus_rstart();
      put_byte(addr_byte(1'b1), ack);
      chk("R8 address ACK after repeated START", int'(ack), 1);
      build_expect(2);
      get_byte(1'b0, got);
      chk("R8 high byte after repeated START", int'(got), exp_q[0]);
      get_byte(1'b1, got);
      chk("R8 low byte after repeated START", int'(got), exp_q[1]);
      bus_stop();

      // R1: new strap value moves the address
      strap_addr = 2'b10;
      #Q;
      run_read(1'b1, 8'b10_00_0_01_0, 2, "R1 R4 readback at changed strap address", -1, 1'b1);

      chk("R10 drive stable while SCL high", r10_viol, 0);
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule